// File: doc/BRIEF.md
# Prescaled Auto-Reload 8-bit Timer

This block is an 8-bit up-counting timer for a small controller. It takes its count pulses from one of two single-cycle clock-enable inputs in the system clock domain: the instruction-cycle enable or the fast-oscillator enable. A free-running prescaler divides the chosen source by a power of two from 2 to 256. When the counter wraps, it reloads from a buffered start value and sets a sticky overflow flag.

Software configures the timer with a single control write. That write carries the run bit, the source select, the 3-bit rate code and the interrupt enable. Software can also write the counter directly and write the reload buffer at any time. A separate clear input drops the flag. The interrupt request is the flag gated by the enable. The wake output follows the request unless the low-power input is high.

Top module: `reload_timer8`

## Requirements
- R1: While the run bit is 0 the count holds and the prescaler is held at zero. While it is 1 the count rises by one on each prescaler tick.
- R2: A tick that finds the count at 0xFF is an overflow. It sets the overflow flag, and the flag stays at 1 until a clear request.
- R3: On overflow the count takes the reload buffer value instead of 0x00. No extra control bit is needed for this.
- R4: A reload-buffer write does not change the count. The written value is used at the next overflow.
- R5: Source select 0 counts pulses on the instruction-cycle enable. Source select 1 counts pulses on the fast-oscillator enable. Pulses on the unselected input are ignored.
- R6: The rate code maps to the divider as follows: 7 → /2, 6 → /4, 5 → /8, 4 → /16, 3 → /32, 2 → /64, 1 → /128, 0 → /256. After the prescaler is cleared, the Nth selected pulse gives the first tick.
- R7: The interrupt request is 1 exactly when the flag is 1 and the interrupt-enable bit is 1.
- R8: The wake output equals the interrupt request while the low-power input is 0, and it is forced to 0 while that input is 1. Counting and flagging continue in low-power mode.
- R9: A direct count write is visible on the next cycle. It takes priority over a coincident tick and never sets the flag.
- R10: A clear request in the same cycle as an overflow leaves the flag at 1. A clear request with no overflow drops the flag on the next cycle.
- R11: Reset clears the count, the reload buffer, the prescaler, the flag and all control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icyc_pulse | input | 1 | Instruction-cycle clock enable pulse |
| fosc_pulse | input | 1 | Fast-oscillator clock enable pulse |
| cfg_we | input | 1 | Control register write strobe |
| cfg_run | input | 1 | Run bit written by cfg_we |
| cfg_src | input | 1 | Source select written by cfg_we (0 instruction, 1 oscillator) |
| cfg_rate | input | 3 | Rate code written by cfg_we |
| cfg_ie | input | 1 | Interrupt enable written by cfg_we |
| cnt_we | input | 1 | Direct count write strobe |
| cnt_wdata | input | 8 | Direct count write value |
| rld_we | input | 1 | Reload buffer write strobe |
| rld_wdata | input | 8 | Reload buffer write value |
| flag_clr | input | 1 | Overflow flag clear request |
| lowpwr | input | 1 | Low-power mode indication |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |
| wake | output | 1 | Wake request |

## Verification
The properties assume that the write strobes and the clear request are synchronous, single-cycle-clean inputs sampled at the rising edge. They also assume the two enable inputs are plain pulses in the same clock domain. The checks rely on the run bit being visible as state, so that a held count can be judged against it.

The stimulus changes every input only on the falling edge and drives each strobe for exactly one cycle. It clears the prescaler by cycling the run bit before any test that depends on pulse phase. This way, every tick lands on a known pulse.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  localparam int RATE_W = 3;

  typedef enum logic {
    SRC_ICYC = 1'b0,
    SRC_FOSC = 1'b1
  } rtim_src_e;

  typedef struct packed {
    logic              run;
    rtim_src_e         src;
    logic [RATE_W-1:0] rate;
    logic              ie;
  } rtim_cfg_t;
endpackage

// File: rtl/rtim_prescaler.sv
module rtim_prescaler #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          src_pulse,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int PW = 2 ** RW;

  logic [PW-1:0] div_q, div_d;
  logic [PW-1:0] mask;
  logic [RW-1:0] sel;

  // code 0 watches the top bit (slowest), the highest code watches bit 0
  always_comb begin
    sel = RW'(PW - 1) - rate;
    for (int i = 0; i < PW; i++) begin
      mask[i] = (i <= int'(sel));
    end
  end

  assign tick = en && src_pulse && ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (!en) begin
      div_d = '0;
    end else if (src_pulse) begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/rtim_counter.sv
module rtim_counter #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          rld_en,
  input  logic [TW-1:0] rld_data,
  output logic [TW-1:0] count,
  output logic          ovf
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] rld_q, rld_d;

  assign ovf = tick && !wr_en && (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (ovf) begin
      cnt_d = rld_q;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
    rld_d = rld_en ? rld_data : rld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/rtim_flag.sv
module rtim_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  // a set in the same cycle as a clear wins
  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import rtim_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icyc_pulse,
  input  logic              fosc_pulse,
  input  logic              cfg_we,
  input  logic              cfg_run,
  input  logic              cfg_src,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_ie,
  input  logic              cnt_we,
  input  logic [TW-1:0]     cnt_wdata,
  input  logic              rld_we,
  input  logic [TW-1:0]     rld_wdata,
  input  logic              flag_clr,
  input  logic              lowpwr,
  output logic [TW-1:0]     count,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wake
);
  rtim_cfg_t cfg_q, cfg_d;
  logic      src_pulse;
  logic      tick;
  logic      ovf;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.run  = cfg_run;
      cfg_d.src  = rtim_src_e'(cfg_src);
      cfg_d.rate = cfg_rate;
      cfg_d.ie   = cfg_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign src_pulse = (cfg_q.src == SRC_FOSC) ? fosc_pulse : icyc_pulse;

  rtim_prescaler #(.RW(RATE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_q.run),
    .src_pulse (src_pulse),
    .rate      (cfg_q.rate),
    .tick      (tick)
  );

  rtim_counter #(.TW(TW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (cnt_we),
    .wr_data  (cnt_wdata),
    .rld_en   (rld_we),
    .rld_data (rld_wdata),
    .count    (count),
    .ovf      (ovf)
  );

  rtim_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovf),
    .clr   (flag_clr),
    .flag  (ovf_flag)
  );

  assign irq  = ovf_flag && cfg_q.ie;
  assign wake = irq && !lowpwr;
endmodule

// File: rtl/reload_timer8_chk.sv
module reload_timer8_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cnt_we,
  input logic [TW-1:0] cnt_wdata,
  input logic          flag_clr,
  input logic          lowpwr,
  input logic [TW-1:0] count,
  input logic          ovf_flag,
  input logic          irq,
  input logic          wake
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(count));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  p_rise_at_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(count) == {TW{1'b1}}));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);

  p_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr |-> !wake);

  p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));
endmodule

bind reload_timer8 reload_timer8_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (cfg_q.run),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .flag_clr  (flag_clr),
  .lowpwr    (lowpwr),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .wake      (wake)
);

// File: tb/reload_timer8_test.sv
module reload_timer8_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       icyc_pulse, fosc_pulse;
  logic       cfg_we, cfg_run, cfg_src, cfg_ie;
  logic [2:0] cfg_rate;
  logic       cnt_we, rld_we, flag_clr, lowpwr;
  logic [7:0] cnt_wdata, rld_wdata;
  logic [7:0] count;
  logic       ovf_flag, irq, wake;

  int checks = 0;
  int errors = 0;

  // rate code / expected divide ratio
  localparam int VEC [8][2] = '{
    '{0, 256}, '{1, 128}, '{2, 64}, '{3, 32},
    '{4, 16},  '{5, 8},   '{6, 4},  '{7, 2}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer8 uut (
    .clk(clk), .rst_n(rst_n), .icyc_pulse(icyc_pulse), .fosc_pulse(fosc_pulse),
    .cfg_we(cfg_we), .cfg_run(cfg_run), .cfg_src(cfg_src), .cfg_rate(cfg_rate),
    .cfg_ie(cfg_ie), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rld_we(rld_we),
    .rld_wdata(rld_wdata), .flag_clr(flag_clr), .lowpwr(lowpwr),
    .count(count), .ovf_flag(ovf_flag), .irq(irq), .wake(wake)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    icyc_pulse = 0; fosc_pulse = 0; cfg_we = 0; cnt_we = 0;
    rld_we = 0; flag_clr = 0;
  endtask

  task automatic set_cfg(input bit run, input bit src, input int rate, input bit ie);
    @(negedge clk);
    cfg_we = 1; cfg_run = run; cfg_src = src; cfg_rate = 3'(rate); cfg_ie = ie;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse(input bit ic, input bit fo, input bit clr);
    @(negedge clk);
    icyc_pulse = ic; fosc_pulse = fo; flag_clr = clr;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk);
    cnt_we = 1; cnt_wdata = 8'(v);
    @(negedge clk);
    idle();
  endtask

  task automatic wr_rld(input int v);
    @(negedge clk);
    rld_we = 1; rld_wdata = 8'(v);
    @(negedge clk);
    idle();
  endtask

  // restart prescaler from zero with given settings
  task automatic restart(input bit src, input int rate, input bit ie);
    set_cfg(0, src, rate, ie);
    set_cfg(1, src, rate, ie);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    cfg_run = 0; cfg_src = 0; cfg_rate = 0; cfg_ie = 0;
    cnt_wdata = 0; rld_wdata = 0; lowpwr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk("R11 count", count, 0);
    chk("R11 flag", ovf_flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 wake", wake, 0);

    // R6 rate table walk
    foreach (VEC[i]) begin
      wr_cnt(0);
      restart(0, VEC[i][0], 0);
      for (int p = 0; p < VEC[i][1] - 1; p++) pulse(1, 0, 0);
      chk($sformatf("R6 code %0d before tick", VEC[i][0]), count, 0);
      pulse(1, 0, 0);
      chk($sformatf("R6 code %0d at tick", VEC[i][0]), count, 1);
    end

    // R1 disabled holds
    set_cfg(0, 0, 7, 0);
    for (int p = 0; p < 6; p++) pulse(1, 0, 0);
    chk("R1 hold while stopped", count, 1);

    // R5 source select
    wr_cnt(8'h20);
    restart(1, 7, 0);
    for (int p = 0; p < 4; p++) pulse(1, 0, 0);
    chk("R5 unselected ignored", count, 8'h20);
    pulse(0, 1, 0); pulse(0, 1, 0);
    chk("R5 oscillator source counts", count, 8'h21);

    // R2 R3 overflow and reload
    wr_rld(8'h40);
    wr_cnt(8'hFE);
    restart(0, 7, 0);
    pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R1 increment to FF", count, 8'hFF);
    chk("R2 no flag before wrap", ovf_flag, 0);
    pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R3 reload value", count, 8'h40);
    chk("R2 flag set", ovf_flag, 1);
    pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R2 flag sticky", ovf_flag, 1);

    // R4 reload buffer write mid-count
    wr_rld(8'h10);
    chk("R4 count unchanged", count, 8'h41);
    wr_cnt(8'hFF);
    restart(0, 7, 0);
    pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R4 new reload used", count, 8'h10);

    // R10 clear alone, then clear colliding with overflow
    pulse(0, 0, 1);
    chk("R10 plain clear", ovf_flag, 0);
    wr_cnt(8'hFF);
    restart(0, 7, 0);
    pulse(1, 0, 0);
    pulse(1, 0, 1);
    chk("R10 collision keeps flag", ovf_flag, 1);
    chk("R10 collision reload", count, 8'h10);

    // R9 direct write does not set flag
    pulse(0, 0, 1);
    wr_cnt(8'hFF);
    wr_cnt(8'h00);
    chk("R9 written value", count, 0);
    chk("R9 no flag", ovf_flag, 0);

    // R7 gating
    wr_cnt(8'hFF);
    restart(0, 7, 0);
    pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R7 flag present", ovf_flag, 1);
    chk("R7 irq off when disabled", irq, 0);
    set_cfg(1, 0, 7, 1);
    chk("R7 irq on", irq, 1);

    // R8 low-power
    @(negedge clk); lowpwr = 1;
    @(negedge clk);
    chk("R8 wake blocked", wake, 0);
    chk("R8 irq still up", irq, 1);
    wr_cnt(8'hFF);
    restart(0, 7, 1);
    pulse(0, 0, 1);
    pulse(1, 0, 0); pulse(1, 0, 0);
    chk("R8 flags in low power", ovf_flag, 1);
    chk("R8 wake blocked after overflow", wake, 0);
    @(negedge clk); lowpwr = 0;
    @(negedge clk);
    chk("R8 wake follows irq", wake, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule